// File: doc/BRIEF.md
# Dithered Third-Order Noise-Shaping Modulator

This block turns a stream of wide signed oversampled samples into a 5-bit level code, one code per accepted sample. A chain of three integrators feeds forward into a summing node ahead of a 32-level quantizer. The loop gains are set so that the quantization error reaches the output shaped by exactly (1 − z⁻¹)³, while the input passes through undelayed. The quantizer level is fed back into the first integrator.

A 35-bit maximal-length shift register supplies a small pseudo-random offset. When enabled, this offset is added at the quantizer input. Because the offset sits inside the loop, it is shaped the same way as the quantization error, and it breaks up the limit cycles that a constant input would otherwise settle into. The modulator advances only on cycles that carry a valid sample, so the surrounding logic sets the oversampled rate. Typical rates are a 6 kHz base rate with 256× oversampling, or 12 kHz with 128×. The level code drives an element-selection stage outside this block.

Top module: `sdm3_mod`

## Requirements
- R1: While `rst` is high at a clock edge, `out_level` becomes 16, all three integrators clear to zero and the dither register loads its nonzero seed (default 1).
- R2: On a clock edge with `in_valid` low, `out_level`, the integrators and the dither register all keep their values.
- R3: Level code k stands for the value (k − 16)·2^(IN_W−5). The code is floor(w / 2^(IN_W−5)) + 16 clipped to 0..31, where w is the quantizer input. It appears on `out_level` at the clock edge that accepts the sample.
- R4: With u the input, v = u − (3e[n−1] − 3e[n−2] + e[n−3]) and e = y − v, the output value is y[n] = u[n] + (1 − z⁻¹)³·e[n]. Here e is zero before the first step after reset, and the quantizer input is w = v + dither.
- R5: With `dither_en` high, the dither equals the register's three low bits times 2^(IN_W−9), which is always below half an output step. With `dither_en` low, the dither is zero.
- R6: The dither register shifts left once per accepted sample, whether or not dither is enabled. Bit 0 takes bit 34 XOR bit 32 (polynomial x³⁵ + x³³ + 1). The register is never zero, and a reduced 7-bit instance (taps 7 and 6) returns to its seed only after 127 steps.
- R7: The integrators clamp at their signed limits instead of wrapping. A full-scale positive input held for 3000 samples keeps `out_level` at 31 throughout, and a full-scale negative input keeps it at 0.
- R8: With dither off and a constant input, the mean output value over 4096 samples is within one output step of the input.
- R9: For a slow ramp, the mean output value over each 512-sample window is within one output step of the mean input over that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe; the loop steps only when high |
| in_sample | input | IN_W | Two's-complement input sample |
| dither_en | input | 1 | Adds the pseudo-random offset at the quantizer input |
| out_level | output | 5 | Quantizer level code, 0..31, mid-scale 16 |

## Verification
The hardest state to reach from the ports is integrator saturation, because a stable loop keeps all three integrators within a few output steps of zero. The bench therefore holds the input at full scale in each direction for thousands of samples, well beyond the point where the second and third integrators would wrap. It then checks that the level code never leaves its rail. The dither path is exercised with gaps in the sample strobe, so that the register state seen by the next sample depends on the hold behaviour. The bench compares every code against a model built on the error-feedback form of the same noise transfer function rather than on integrators.

// File: rtl/sdm3_pkg.sv
`timescale 1ns/1ps
package sdm3_pkg;

    localparam int LVL_W   = 5;
    localparam int LVL_MAX = (1 << LVL_W) - 1;
    localparam int LVL_MID = 1 << (LVL_W - 1);

    typedef logic [LVL_W-1:0] level_t;

    // Map a floor-divided quantizer index to a clipped level code.
    function automatic level_t clip_level(input logic signed [63:0] idx);
        logic signed [63:0] k;
        k = idx + 64'(LVL_MID);
        if (k > 64'(LVL_MAX))
            return level_t'(LVL_MAX);
        else if (k < 64'sd0)
            return '0;
        else
            return level_t'(k);
    endfunction

endpackage

// File: rtl/sdm3_lfsr.sv
`timescale 1ns/1ps
module sdm3_lfsr #(
    parameter int             W    = 35,
    parameter int             TAP  = 33,
    parameter logic [W-1:0]   SEED = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    output logic [W-1:0] state
);

    logic fb;

    always_comb fb = state[W-1] ^ state[TAP-1];

    always_ff @(posedge clk) begin
        if (rst)
            state <= SEED;
        else if (en)
            state <= {state[W-2:0], fb};
    end

endmodule

// File: rtl/sdm3_integ.sv
`timescale 1ns/1ps
module sdm3_integ #(
    parameter int W = 20
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic signed [W-1:0] din,
    output logic signed [W-1:0] acc
);

    localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    logic signed [W:0]   sum;
    logic signed [W-1:0] nxt;

    always_comb begin
        sum = {acc[W-1], acc} + {din[W-1], din};
        if (sum[W] != sum[W-1])
            nxt = sum[W] ? MINV : MAXV;
        else
            nxt = sum[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc <= '0;
        else if (en)
            acc <= nxt;
    end

endmodule

// File: rtl/sdm3_mod.sv
`timescale 1ns/1ps
module sdm3_mod
    import sdm3_pkg::*;
#(
    parameter int                 IN_W      = 16,
    parameter int                 LFSR_W    = 35,
    parameter int                 LFSR_TAP  = 33,
    parameter logic [LFSR_W-1:0]  LFSR_SEED = 1,
    parameter int                 DITH_W    = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic signed [IN_W-1:0] in_sample,
    input  logic                   dither_en,
    output logic [LVL_W-1:0]       out_level
);

    localparam int STEP_LOG = IN_W - LVL_W;
    localparam int IW       = IN_W + 4;
    localparam int WW       = IW + 4;
    localparam int DSH      = STEP_LOG - 1 - DITH_W;
    localparam int NSTG     = 3;

    logic [LFSR_W-1:0]     lfsr_q;
    logic signed [WW-1:0]  dith;
    logic signed [IW-1:0]  feed [NSTG];
    logic signed [IW-1:0]  acc  [NSTG];
    logic signed [WW-1:0]  wsum;
    logic signed [WW-1:0]  widx;
    level_t                qlev;
    logic signed [IW-1:0]  yval;

    sdm3_lfsr #(
        .W    (LFSR_W),
        .TAP  (LFSR_TAP),
        .SEED (LFSR_SEED)
    ) u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .en    (in_valid),
        .state (lfsr_q)
    );

    // Dither: low register bits placed just under half an output step.
    always_comb begin
        dith = '0;
        if (dither_en)
            dith[DSH +: DITH_W] = lfsr_q[DITH_W-1:0];
    end

    // Integrator chain: stage 0 integrates input minus output, each later
    // stage integrates the previous stage's state.
    always_comb begin
        feed[0] = IW'(in_sample) - yval;
        for (int k = 1; k < NSTG; k++)
            feed[k] = acc[k-1];
    end

    for (genvar g = 0; g < NSTG; g++) begin : g_stage
        sdm3_integ #(.W(IW)) u_integ (
            .clk (clk),
            .rst (rst),
            .en  (in_valid),
            .din (feed[g]),
            .acc (acc[g])
        );
    end

    // Feed-forward sum with gains 3, 3, 1, direct input path and dither.
    always_comb begin
        wsum = WW'(in_sample)
             + (WW'(acc[0]) <<< 1) + WW'(acc[0])
             + (WW'(acc[1]) <<< 1) + WW'(acc[1])
             + WW'(acc[2])
             + dith;
        widx = wsum >>> STEP_LOG;
        qlev = clip_level(64'(widx));
        yval = (IW'($signed({1'b0, qlev})) - IW'(LVL_MID)) <<< STEP_LOG;
    end

    always_ff @(posedge clk) begin
        if (rst)
            out_level <= level_t'(LVL_MID);
        else if (in_valid)
            out_level <= qlev;
    end

endmodule

// File: rtl/sdm3_mod_chk.sv
`timescale 1ns/1ps
module sdm3_mod_chk #(
    parameter int LFSR_W = 35,
    parameter int WW     = 24,
    parameter int DLIM   = 1024
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic [4:0]           out_level,
    input logic [LFSR_W-1:0]    lfsr_q,
    input logic signed [WW-1:0] dith
);

    AST_RESET_MID: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> out_level == 5'd16); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_level) && $stable(lfsr_q)); // R2

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
        lfsr_q != '0); // R6

    AST_LFSR_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> lfsr_q != $past(lfsr_q)); // R6

    AST_DITHER_BOUND: assert property (@(posedge clk) disable iff (rst)
        dith >= 0 && dith < DLIM); // R5

endmodule

bind sdm3_mod sdm3_mod_chk #(
    .LFSR_W (LFSR_W),
    .WW     (WW),
    .DLIM   (1 << (STEP_LOG - 1))
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_level (out_level),
    .lfsr_q    (lfsr_q),
    .dith      (dith)
);

// File: tb/sdm3_mod_tb.sv
`timescale 1ns/1ps
module sdm3_mod_tb_top;

    localparam int IN_W     = 16;
    localparam int STEP_LOG = IN_W - 5;
    localparam longint STEP = 64'sd1 << STEP_LOG;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   in_valid = 1'b0;
    logic signed [IN_W-1:0] in_sample = '0;
    logic                   dither_en = 1'b0;
    logic [4:0]             out_level;

    logic       s_rst = 1'b1;
    logic       s_en  = 1'b0;
    logic [6:0] s_state;

    int checks   = 0;
    int failures = 0;
    int got_q    = 0;

    // reference model state
    longint      e1, e2, e3;
    logic [34:0] lf;
    int          last_q;

    always #2 clk = ~clk;

    sdm3_mod #(.IN_W(IN_W)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .dither_en (dither_en),
        .out_level (out_level)
    );

    sdm3_lfsr #(.W(7), .TAP(6), .SEED(7'h01)) small_i (
        .clk   (clk),
        .rst   (s_rst),
        .en    (s_en),
        .state (s_state)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        e1 = 0; e2 = 0; e3 = 0;
        lf = 35'h1;
        last_q = 16;
    endtask

    // Error-feedback form of the loop: v = u - (3e1 - 3e2 + e3).
    task automatic model_step(input longint u, input bit den, output int q);
        longint d, v, w, idx, y, e;
        d = den ? (longint'(lf[2:0]) <<< (STEP_LOG - 4)) : 0;
        v = u - (3 * e1 - 3 * e2 + e3);
        w = v + d;
        idx = w >>> STEP_LOG;
        idx = idx + 16;
        if (idx > 31) idx = 31;
        if (idx < 0)  idx = 0;
        q = int'(idx);
        y = (idx - 16) * STEP;
        e = y - v;
        e3 = e2; e2 = e1; e1 = e;
        lf = {lf[33:0], lf[34] ^ lf[32]};
        last_q = q;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        @(posedge clk); #1;
        check(out_level == 5'd16, "R1", out_level, 16);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    // One clock: drive at negedge, sample 1 ns after the rising edge.
    task automatic run(input longint u, input bit vld, input bit den, input bit cmp, input string req);
        int exp_q;
        @(negedge clk);
        in_sample = IN_W'(u);
        in_valid  = vld;
        dither_en = den;
        if (vld) model_step(u, den, exp_q);
        else     exp_q = last_q;
        @(posedge clk); #1;
        got_q = int'(out_level);
        if (cmp) check(got_q == exp_q, req, got_q, exp_q);
    endtask

    initial begin
        #800000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        longint sum_y, sum_u, u;
        int first_ret;
        model_reset();
        repeat (3) @(negedge clk);
        do_reset();

        // R3: level mapping and one-edge latency
        @(negedge clk);
        in_sample = IN_W'(3 * STEP); in_valid = 1'b1; dither_en = 1'b0;
        #1;
        check(out_level == 5'd16, "R3", out_level, 16);
        @(posedge clk); #1;
        check(out_level == 5'd19, "R3", out_level, 19);
        do_reset();

        // R4: zero and step inputs, dither off
        for (int n = 0; n < 300; n++) run(0, 1'b1, 1'b0, 1'b1, "R4");
        for (int n = 0; n < 300; n++) run(-3000, 1'b1, 1'b0, 1'b1, "R4");

        // R8: constant input, long-run mean
        do_reset();
        sum_y = 0;
        for (int n = 0; n < 4096; n++) begin
            run(5000, 1'b1, 1'b0, 1'b1, "R4");
            sum_y += (longint'(got_q) - 16) * STEP;
        end
        check((sum_y / 4096 - 5000) <= STEP && (5000 - sum_y / 4096) <= STEP, "R8", sum_y / 4096, 5000);

        // R5 and R2: dither on, strobe gaps
        do_reset();
        for (int n = 0; n < 2000; n++) begin
            if (n % 5 == 3) run(-7000, 1'b0, 1'b1, 1'b1, "R2");
            else            run(-7000, 1'b1, 1'b1, 1'b1, "R5");
        end

        // R1: reset mid-stream, then model alignment resumes
        do_reset();
        for (int n = 0; n < 200; n++) run(1234, 1'b1, 1'b1, 1'b1, "R1");

        // R9: slow ramp with dither, windowed means
        do_reset();
        sum_y = 0; sum_u = 0;
        for (int n = 0; n < 8192; n++) begin
            u = -8000 + 2 * n;
            run(u, 1'b1, 1'b1, 1'b1, "R5");
            sum_y += (longint'(got_q) - 16) * STEP;
            sum_u += u;
            if (n % 512 == 511) begin
                check((sum_y - sum_u) / 512 <= STEP && (sum_u - sum_y) / 512 <= STEP,
                      "R9", sum_y / 512, sum_u / 512);
                sum_y = 0; sum_u = 0;
            end
        end

        // R7: overload each way; clamping keeps the code on its rail
        do_reset();
        for (int n = 0; n < 3000; n++) begin
            run(32767, 1'b1, 1'b0, 1'b0, "R7");
            if (n >= 4) check(got_q == 31, "R7", got_q, 31);
        end
        do_reset();
        for (int n = 0; n < 3000; n++) begin
            run(-32768, 1'b1, 1'b0, 1'b0, "R7");
            if (n >= 4) check(got_q == 0, "R7", got_q, 0);
        end

        // R6: reduced-width register period
        @(negedge clk); s_rst = 1'b1;
        @(negedge clk); s_rst = 1'b0; s_en = 1'b1;
        first_ret = 0;
        for (int n = 1; n <= 130; n++) begin
            @(posedge clk); #1;
            check(s_state != 7'h0, "R6", s_state, 1);
            if (s_state == 7'h01 && first_ret == 0) first_ret = n;
        end
        @(negedge clk); s_en = 1'b0;
        check(first_ret == 127, "R6", first_ret, 127);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule